// File: doc/BRIEF.md
# Fully Associative Write-Back Cache with Sequential Tag Scan

This block is a write-back data cache in which any memory line may sit in any of its line slots (256 by default, 16 bytes each, so 4 KB). A processor side issues word loads and stores with 32-bit byte addresses over a valid/ready pair. The upper 28 address bits are the tag and the low 4 bits pick the byte within a line. Each slot holds a valid flag, a dirty flag, a tag and a recency age. Instead of comparing every tag at once, a state machine walks the slots one per cycle. During the walk it looks for a matching tag, notes the first empty slot, and notes the slot whose age marks it as least recently used.

On a miss the block fills an empty slot if there is one. Otherwise it evicts the least recently used slot. A dirty victim is first written back to memory as a whole line. The refill then reads a whole line over a block-wide memory port that has a done handshake. Every completed request, hit or miss, load or store, ends with a one-cycle response pulse that carries the addressed word.

States: `ST_IDLE` (ready, waiting), `ST_SCAN` (one slot per cycle), `ST_PICK` (victim chosen), `ST_EVICT` (line write-back), `ST_REFILL` (line read), `ST_ACCESS` (word read/merge, recency update, response). The transitions are:
- IDLE→SCAN on an accepted request.
- SCAN→ACCESS on a tag match.
- SCAN→PICK after the last slot with no match.
- PICK→EVICT when the victim is valid and dirty.
- PICK→REFILL otherwise.
- EVICT→REFILL on memory done.
- REFILL→ACCESS on memory done.
- ACCESS→IDLE always.

Top module: `fa_lru_cache`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_req` are 0. Every slot is empty, so the first access to any line misses.
- R2: A load whose line is resident returns the current word of that address without any memory transfer.
- R3: A miss while an empty slot exists performs exactly one line read (`mem_we`=0) and no write-back. A freshly filled slot is valid and clean.
- R4: Requests are word aligned (address bits [1:0] are 0), and address bits [3:2] select the word in the line. A store updates only the byte lanes whose `req_wstrb` bit is 1 (bit n covers data bits [8n+7:8n]), keeps the other bytes, and marks the slot dirty.
- R5: A miss with every slot valid evicts the slot that was accessed least recently.
- R6: A dirty victim is written back as one whole line to address {victim tag, 4'b0000} before the refill read. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_done`. Data written back and later reloaded matches the last stored values.
- R7: A clean victim is replaced with a refill read only, with no write-back.
- R8: `req_ready` is low from the cycle after acceptance until the request completes. Requests are taken only while `req_ready` is high.
- R9: Each accepted request produces exactly one `resp_valid` pulse, one cycle long.
- R10: Each hit or fill makes the accessed slot the newest. Slots that were newer than it age by one, so the ages stay a permutation with exactly one oldest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| req_wstrb | input | 4 | Store byte-lane enables |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Addressed word (load result) |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written back |
| mem_rdata | input | 128 | Line returned by a refill |
| mem_done | input | 1 | Memory transfer complete (one cycle) |

## Verification
The bench builds the cache with 8 slots in place of 256. With so few slots the capacity point is reached after eight distinct lines, so both eviction and the full age ordering can be driven directly in short directed sequences. A random mix over twelve lines with four words each then keeps the cache full and forces repeated dirty and clean evictions. Each load is compared against a word-level model of memory, so lost or stale write-back data shows up as a data mismatch.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PICK,
        ST_EVICT,
        ST_REFILL,
        ST_ACCESS
    } cache_state_e;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/fa_line_meta.sv
module fa_line_meta #(
    parameter int LINES = 256,
    parameter int TAG_W = 28,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_en
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= 1'b0;
        end else if (dirty_en) begin
            dirty_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[wr_idx] <= fill_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(wr_idx)] && !dirty_q[$past(wr_idx)])); // R3

    AST_STORE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_en && !fill_en) |=> dirty_q[$past(wr_idx)]); // R4

endmodule

// File: rtl/fa_recency.sv
module fa_recency #(
    parameter int LINES = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_oldest,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx
);

    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(LINES - 1);

    logic [IDX_W-1:0] age_q [LINES];
    logic [LINES-1:0] oldest_vec;
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    for (genvar i = 0; i < LINES; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[i] <= IDX_W'(i);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(i)) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < touched_age) begin
                    age_q[i] <= age_q[i] + IDX_W'(1);
                end
            end
        end
        assign oldest_vec[i] = (age_q[i] == AGE_MAX);
    end

    assign rd_oldest = oldest_vec[rd_idx];

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1); // R10

    AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (age_q[$past(touch_idx)] == '0)); // R10

endmodule

// File: rtl/fa_line_data.sv
module fa_line_data #(
    parameter int LINES      = 256,
    parameter int IDX_W      = 8,
    parameter int LINE_BYTES = 16,
    parameter int SEL_W      = 2
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [LINE_BYTES*8-1:0] rd_line,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    full_en,
    input  logic [LINE_BYTES*8-1:0] full_data,
    input  logic                    word_en,
    input  logic [SEL_W-1:0]        word_sel,
    input  logic [31:0]             word_data,
    input  logic [3:0]              word_strb
);

    localparam int LINE_W = LINE_BYTES * 8;

    logic [LINE_W-1:0]     line_q [LINES];
    logic [LINE_BYTES-1:0] byte_we;
    logic [LINE_W-1:0]     merged;

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        assign byte_we[b] = word_en && (word_sel == SEL_W'(b / 4)) && word_strb[b % 4];
    end

    always_comb begin
        merged = line_q[wr_idx];
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (byte_we[b]) begin
                merged[b*8 +: 8] = word_data[(b % 4)*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (full_en) begin
            line_q[wr_idx] <= full_data;
        end else if (word_en) begin
            line_q[wr_idx] <= merged;
        end
    end

    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/fa_lru_cache.sv
module fa_lru_cache
    import fa_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 256,
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_we,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [31:0]             req_wdata,
    input  logic [3:0]              req_wstrb,
    output logic                    resp_valid,
    output logic [31:0]             resp_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    input  logic [LINE_BYTES*8-1:0] mem_rdata,
    input  logic                    mem_done
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(LINES);
    localparam int SEL_W  = $clog2(LINE_BYTES / WORD_BYTES);
    localparam int WADR_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    cache_state_e state_q, state_d;

    logic [IDX_W-1:0]  ptr_q, tgt_q, free_q, old_q;
    logic              free_found_q;
    logic              lat_we_q;
    logic [WADR_W-1:0] lat_waddr_q;
    logic [31:0]       lat_wdata_q;
    logic [3:0]        lat_wstrb_q;

    logic [TAG_W-1:0]  lat_tag;
    logic [SEL_W-1:0]  lat_sel;
    logic [IDX_W-1:0]  victim;
    logic [IDX_W-1:0]  rd_idx;
    logic              meta_valid, meta_dirty, meta_oldest;
    logic [TAG_W-1:0]  meta_tag;
    logic [LINE_BYTES*8-1:0] line_rd;
    logic              hit_now;
    logic              fill_en, store_en, touch_en;

    assign lat_tag = lat_waddr_q[WADR_W-1 : OFF_W-2];
    assign lat_sel = lat_waddr_q[SEL_W-1:0];
    assign victim  = free_found_q ? free_q : old_q;

    always_comb begin
        unique case (state_q)
            ST_SCAN: rd_idx = ptr_q;
            ST_PICK: rd_idx = victim;
            default: rd_idx = tgt_q;
        endcase
    end

    assign hit_now = (state_q == ST_SCAN) && meta_valid && (meta_tag == lat_tag);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SCAN;
            ST_SCAN:   if (hit_now) state_d = ST_ACCESS;
                       else if (ptr_q == LAST_IDX) state_d = ST_PICK;
            ST_PICK:   state_d = (meta_valid && meta_dirty) ? ST_EVICT : ST_REFILL;
            ST_EVICT:  if (mem_done) state_d = ST_REFILL;
            ST_REFILL: if (mem_done) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and scan bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ptr_q        <= '0;
            tgt_q        <= '0;
            free_q       <= '0;
            old_q        <= '0;
            free_found_q <= 1'b0;
            lat_we_q     <= 1'b0;
            lat_waddr_q  <= '0;
            lat_wdata_q  <= '0;
            lat_wstrb_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    lat_we_q     <= req_we;
                    lat_waddr_q  <= req_addr[ADDR_W-1:2];
                    lat_wdata_q  <= req_wdata;
                    lat_wstrb_q  <= req_wstrb;
                    ptr_q        <= '0;
                    free_found_q <= 1'b0;
                end
                ST_SCAN: begin
                    ptr_q <= ptr_q + IDX_W'(1);
                    if (hit_now) tgt_q <= ptr_q;
                    if (!meta_valid && !free_found_q) begin
                        free_found_q <= 1'b1;
                        free_q       <= ptr_q;
                    end
                    if (meta_valid && meta_oldest) old_q <= ptr_q;
                end
                ST_PICK: tgt_q <= victim;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_ACCESS);
        resp_rdata = line_rd[lat_sel*32 +: 32];
        mem_req    = (state_q == ST_EVICT) || (state_q == ST_REFILL);
        mem_we     = (state_q == ST_EVICT);
        mem_addr   = (state_q == ST_EVICT) ? {meta_tag, {OFF_W{1'b0}}}
                                           : {lat_tag, {OFF_W{1'b0}}};
        mem_wdata  = line_rd;
        fill_en    = (state_q == ST_REFILL) && mem_done;
        store_en   = (state_q == ST_ACCESS) && lat_we_q;
        touch_en   = (state_q == ST_ACCESS);
    end

    fa_line_meta #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_meta (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (meta_valid),
        .rd_dirty (meta_dirty),
        .rd_tag   (meta_tag),
        .wr_idx   (tgt_q),
        .fill_en  (fill_en),
        .fill_tag (lat_tag),
        .dirty_en (store_en)
    );

    fa_recency #(.LINES(LINES), .IDX_W(IDX_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_oldest (meta_oldest),
        .touch_en  (touch_en),
        .touch_idx (tgt_q)
    );

    fa_line_data #(.LINES(LINES), .IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES), .SEL_W(SEL_W)) u_data (
        .clk       (clk),
        .rd_idx    (rd_idx),
        .rd_line   (line_rd),
        .wr_idx    (tgt_q),
        .full_en   (fill_en),
        .full_data (mem_rdata),
        .word_en   (store_en),
        .word_sel  (lat_sel),
        .word_data (lat_wdata_q),
        .word_strb (lat_wstrb_q)
    );

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R6

    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (meta_valid && meta_dirty)); // R6

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        hit_now |=> !mem_req); // R2

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_addr[1:0] == 2'b00)); // R4

endmodule

// File: tb/fa_lru_cache_tb.sv
module fa_lru_cache_tb;

    localparam int LINES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         req_valid = 1'b0, req_we = 1'b0;
    logic         req_ready, resp_valid, mem_req, mem_we;
    logic [31:0]  req_addr = '0, req_wdata = '0, resp_rdata, mem_addr;
    logic [3:0]   req_wstrb = '0;
    logic [127:0] mem_wdata, mem_rdata;
    logic         mem_done;

    fa_lru_cache #(.LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0;
    logic [31:0]  last_wr_addr = '0;
    logic [127:0] last_wr_data = '0;
    logic [127:0] bmem [logic [27:0]];
    logic [31:0]  refw [logic [29:0]];

    function automatic logic [31:0] seed_word(input logic [29:0] wa);
        return (32'(wa) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [127:0] mem_line(input logic [27:0] la);
        if (bmem.exists(la)) return bmem[la];
        return {seed_word({la, 2'd3}), seed_word({la, 2'd2}),
                seed_word({la, 2'd1}), seed_word({la, 2'd0})};
    endfunction

    function automatic logic [31:0] ref_word(input logic [29:0] wa);
        logic [127:0] l;
        if (refw.exists(wa)) return refw[wa];
        l = mem_line(wa[29:2]);
        return l[wa[1:0]*32 +: 32];
    endfunction

    function automatic logic [31:0] line_addr(input int k, input int w);
        return 32'h1001_0000 + 32'(k) * 32'd16 + 32'(w) * 32'd4;
    endfunction

    // behavioural memory: three-cycle latency, one-cycle done pulse
    initial begin
        int lat;
        lat = 0;
        mem_done = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            mem_done <= 1'b0;
            if (mem_req && !mem_done) begin
                lat++;
                if (lat == 3) begin
                    lat = 0;
                    mem_done <= 1'b1;
                    if (mem_we) begin
                        bmem[mem_addr[31:4]] = mem_wdata;
                        n_wr++;
                        last_wr_addr = mem_addr;
                        last_wr_data = mem_wdata;
                    end else begin
                        mem_rdata <= mem_line(mem_addr[31:4]);
                        n_rd++;
                    end
                end
            end
        end
    end

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        refw.delete();
    endtask

    task automatic do_req(input logic we, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] s, input bit check_hs, output logic [31:0] r);
        logic busy;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_wstrb = s;
        @(negedge clk);
        req_valid = 1'b0;
        busy = req_ready;
        while (!resp_valid) @(negedge clk);
        r = resp_rdata;
        @(negedge clk);
        if (check_hs) begin
            chk(128'(busy), 128'(0), "R8 ready low while busy");
            chk(128'(resp_valid), 128'(0), "R9 response single pulse");
        end
        if (we) begin
            logic [31:0] o;
            o = ref_word(a[31:2]);
            for (int b = 0; b < 4; b++) if (s[b]) o[b*8 +: 8] = d[b*8 +: 8];
            refw[a[31:2]] = o;
        end
    endtask

    task automatic load_chk(input logic [31:0] a, input string tag);
        logic [31:0] r;
        do_req(1'b0, a, 32'h0, 4'h0, 1'b0, r);
        chk(128'(r), 128'(ref_word(a[31:2])), tag);
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] r;
        do_req(1'b1, a, d, s, 1'b0, r);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rd0, wr0;
        logic [31:0] r;
        logic [127:0] exp_line;
        do_reset();
        chk(128'(req_ready), 128'(1), "R1 ready after reset");
        chk(128'(resp_valid), 128'(0), "R1 resp_valid after reset");
        chk(128'(mem_req), 128'(0), "R1 mem_req after reset");

        // R3 cold fill / R1 first access misses
        rd0 = n_rd; wr0 = n_wr;
        do_req(1'b0, line_addr(0, 1), 32'h0, 4'h0, 1'b1, r);
        chk(128'(r), 128'(ref_word(line_addr(0, 1) >> 2)), "R3 cold load data");
        chk(128'(n_rd - rd0), 128'(1), "R1 R3 one refill read");
        chk(128'(n_wr - wr0), 128'(0), "R3 no write-back on free fill");

        // R2 hit: no memory transfer
        rd0 = n_rd;
        load_chk(line_addr(0, 2), "R2 hit load data");
        chk(128'(n_rd - rd0), 128'(0), "R2 hit makes no memory read");

        // R4 partial store then read back
        store(line_addr(0, 1), 32'hA1B2C3D4, 4'b0101);
        load_chk(line_addr(0, 1), "R4 strobe merge");

        // fill remaining slots with dirty lines (free fills, no write-back)
        wr0 = n_wr;
        for (int k = 1; k < LINES; k++) store(line_addr(k, 0), 32'hC0DE0000 + 32'(k), 4'hF);
        chk(128'(n_wr - wr0), 128'(0), "R3 free fills write nothing back");
        load_chk(line_addr(0, 0), "R2 refresh slot of line 0");

        // R5 R6: line 1 is now least recent and dirty
        exp_line = {ref_word(line_addr(1, 3) >> 2), ref_word(line_addr(1, 2) >> 2),
                    ref_word(line_addr(1, 1) >> 2), ref_word(line_addr(1, 0) >> 2)};
        wr0 = n_wr;
        load_chk(line_addr(LINES, 0), "R5 capacity miss data");
        chk(128'(n_wr - wr0), 128'(1), "R6 dirty victim written back");
        chk(128'(last_wr_addr), 128'(line_addr(1, 0)), "R5 LRU victim address");
        chk(last_wr_data, exp_line, "R6 write-back line content");

        // R10 aging: line 2 is next oldest
        load_chk(line_addr(LINES + 1, 0), "R10 second capacity miss data");
        chk(128'(last_wr_addr), 128'(line_addr(2, 0)), "R10 next victim after aging");
        load_chk(line_addr(1, 0), "R6 reload of written-back line");

        // R7 clean victims
        do_reset();
        for (int k = 0; k < LINES; k++) load_chk(line_addr(k, 2), "R7 clean fill data");
        rd0 = n_rd; wr0 = n_wr;
        load_chk(line_addr(LINES, 2), "R7 clean eviction data");
        chk(128'(n_wr - wr0), 128'(0), "R7 no write-back of clean victim");
        chk(128'(n_rd - rd0), 128'(1), "R7 single refill read");
        load_chk(line_addr(0, 2), "R5 reload of evicted oldest");
        rd0 = n_rd;
        load_chk(line_addr(2, 2), "R5 survivor still resident");
        chk(128'(n_rd - rd0), 128'(0), "R5 survivor hit without read");

        // random mix over 12 lines
        for (int i = 0; i < 400; i++) begin
            int k, w;
            k = int'($urandom_range(11, 0));
            w = int'($urandom_range(3, 0));
            if ($urandom_range(1, 0) == 1)
                store(line_addr(k, w), $urandom(), 4'($urandom_range(15, 1)));
            else
                load_chk(line_addr(k, w), "R4 R6 random load vs model");
        end
        do_req(1'b0, line_addr(3, 3), 32'h0, 4'h0, 1'b1, r);
        chk(128'(r), 128'(ref_word(line_addr(3, 3) >> 2)), "R2 final load");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
    end

endmodule